// File: doc/BRIEF.md
# Successive-Approximation Register with Early Stop and Auto-Restart

This block holds the digital side of a successive-approximation converter. The result register has `WIDTH` bits. An external comparator supplies one decision per clock. The register tries each bit from the most significant downward: it sets the trial bit high, then keeps or clears it on the next clock according to the comparator. The decision just made also leaves on a serial output.

A conversion starts in one of two cases: the start request rises while a conversion is running, or the request is high while the done flag is up. A request held high therefore keeps the register converting back to back. Feeding the done flag back into the request gives free-running operation.

The short-stop input ends a running conversion early. Wiring it to the register output just below the last wanted bit makes the register deliver a shorter word. From reset, the done flag is high and the result is zero, so a high request always leads to a conversion. The register has no stable state in which it stops responding, which suits the first stage of a chain of converters.

Top module: `sar_shortening`

## Requirements
- R1: While `rst` is high, and after it is released with no start, `sar_q` is all zeros, `conv_done` is 1 and `ser_bit` is 0.
- R2: When `conv_done` is 1 and `conv_start` is sampled 1, the next clock loads `sar_q` with only the MSB set (0x80 for 8 bits), clears `conv_done` and drives `ser_bit` to 0.
- R3: While `conv_done` is 0, a `conv_start` sampled 1 after having been 0 on the previous clock restarts the conversion with the same loading as R2.
- R4: While `conv_done` is 0, a `conv_start` held at 1, or held at 0, does not restart the conversion.
- R5: Each conversion clock keeps the trial bit when `cmp_bit` is 1 and clears it when `cmp_bit` is 0. In the same clock it sets the next lower bit as the new trial bit. Bits already decided do not change.
- R6: With `short_stop` held at 0, `conv_done` rises on the clock that decides bit 0, which is the eighth clock after the start clock for 8 bits. `sar_q` then holds the comparator's result.
- R7: A `short_stop` sampled 1 during a conversion sets `conv_done` on that clock and leaves `sar_q` unchanged. With `short_stop` driven from `sar_q[1]`, the register gives a 6-bit result in `sar_q[7:2]`, with `sar_q[1:0]` reading 2'b10.
- R8: `short_stop` has no effect while `conv_done` is 1.
- R9: While `conv_done` is 1 and `conv_start` is 0, `sar_q` and `conv_done` hold their values.
- R10: After each conversion clock, and after a short-stop clock, `ser_bit` equals the `cmp_bit` sampled on that clock. It is 0 after a start clock and during holding.
- R11: With `conv_done` fed back to `conv_start`, a new conversion starts on the clock after `conv_done` rises, which gives a period of `WIDTH`+1 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every input is sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| conv_start | input | 1 | Start request, compared with its value on the previous clock |
| short_stop | input | 1 | Ends a running conversion on the clock it is sampled high |
| cmp_bit | input | 1 | Comparator decision for the current trial bit |
| sar_q | output | WIDTH | Parallel result and trial word sent to the DAC |
| conv_done | output | 1 | End of conversion; high while the result is held |
| ser_bit | output | 1 | Serial copy of each decision, MSB first |

## Verification
On every cycle the assertions check four things: the loading done by a start, the freezing of the result while holding, the quiet serial line, and the early stop caused by short-stop. They also check that the serial bit follows the comparator on each conversion clock, and that done only falls when a start request is present. The bench scenarios are needed for the rest. They show that the whole result matches a sampled analog value, that done rises exactly on the bit-0 clock, and that a shortened conversion gives a 6-bit word. They also show that a mid-conversion retrigger restarts the register, and that the free-running loop repeats every nine clocks.

// File: rtl/sar_pkg.sv
package sar_pkg;

    localparam int unsigned SAR_DEF_WIDTH = 8;

    // Action chosen by the sequencer for the coming clock edge
    typedef enum logic [1:0] {
        ACT_IDLE  = 2'd0,   // hold result, serial line quiet
        ACT_START = 2'd1,   // load MSB trial
        ACT_STEP  = 2'd2,   // decide trial bit, move to next
        ACT_CUT   = 2'd3    // early stop from short_stop
    } sar_act_e;

    function automatic logic act_emits_serial(input sar_act_e a);
        return (a == ACT_STEP) || (a == ACT_CUT);
    endfunction

endpackage

// File: rtl/sar_seq.sv
module sar_seq
    import sar_pkg::*;
#(
    parameter int unsigned WIDTH = SAR_DEF_WIDTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             conv_start,
    input  logic             short_stop,
    output sar_act_e         act,
    output logic [WIDTH-1:0] probe,
    output logic             done
);
    localparam logic [WIDTH-1:0] TOP_PROBE = {1'b1, {(WIDTH-1){1'b0}}};

    logic start_prev;

    always_comb begin
        if (conv_start && (done || !start_prev)) begin
            act = ACT_START;
        end else if (done) begin
            act = ACT_IDLE;
        end else if (short_stop) begin
            act = ACT_CUT;
        end else begin
            act = ACT_STEP;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            start_prev <= 1'b0;
            probe      <= '0;
            done       <= 1'b1;
        end else begin
            start_prev <= conv_start;
            unique case (act)
                ACT_START: begin
                    probe <= TOP_PROBE;
                    done  <= 1'b0;
                end
                ACT_CUT: begin
                    probe <= '0;
                    done  <= 1'b1;
                end
                ACT_STEP: begin
                    probe <= probe >> 1;
                    if (probe[0]) begin
                        done <= 1'b1;
                    end
                end
                default: begin
                    probe <= probe;
                end
            endcase
        end
    end

endmodule

// File: rtl/sar_bits.sv
module sar_bits
    import sar_pkg::*;
#(
    parameter int unsigned WIDTH = SAR_DEF_WIDTH
) (
    input  logic             clk,
    input  logic             rst,
    input  sar_act_e         act,
    input  logic [WIDTH-1:0] probe,
    input  logic             cmp_bit,
    output logic [WIDTH-1:0] q
);
    localparam logic [WIDTH-1:0] TOP_PROBE = {1'b1, {(WIDTH-1){1'b0}}};

    logic [WIDTH-1:0] decided;

    // Keep or clear the trial bit, arm the next lower one
    always_comb begin
        decided = (q & ~probe) | (cmp_bit ? probe : '0) | (probe >> 1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            unique case (act)
                ACT_START: q <= TOP_PROBE;
                ACT_STEP:  q <= decided;
                default:   q <= q;
            endcase
        end
    end

endmodule

// File: rtl/sar_serial.sv
module sar_serial
    import sar_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  sar_act_e act,
    input  logic     cmp_bit,
    output logic     ser_bit
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ser_bit <= 1'b0;
        end else begin
            ser_bit <= act_emits_serial(act) ? cmp_bit : 1'b0;
        end
    end

endmodule

// File: rtl/sar_shortening.sv
module sar_shortening
    import sar_pkg::*;
#(
    parameter int unsigned WIDTH = SAR_DEF_WIDTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             conv_start,
    input  logic             short_stop,
    input  logic             cmp_bit,
    output logic [WIDTH-1:0] sar_q,
    output logic             conv_done,
    output logic             ser_bit
);
    sar_act_e         act;
    logic [WIDTH-1:0] probe;

    sar_seq #(.WIDTH(WIDTH)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .conv_start (conv_start),
        .short_stop (short_stop),
        .act        (act),
        .probe      (probe),
        .done       (conv_done)
    );

    sar_bits #(.WIDTH(WIDTH)) u_bits (
        .clk     (clk),
        .rst     (rst),
        .act     (act),
        .probe   (probe),
        .cmp_bit (cmp_bit),
        .q       (sar_q)
    );

    sar_serial u_ser (
        .clk     (clk),
        .rst     (rst),
        .act     (act),
        .cmp_bit (cmp_bit),
        .ser_bit (ser_bit)
    );

endmodule

// File: rtl/sar_shortening_chk.sv
module sar_shortening_chk #(
    parameter int unsigned WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             conv_start,
    input logic             short_stop,
    input logic             cmp_bit,
    input logic [WIDTH-1:0] sar_q,
    input logic             conv_done,
    input logic             ser_bit
);
    localparam logic [WIDTH-1:0] MSB_ONLY = {1'b1, {(WIDTH-1){1'b0}}};

    logic req_prev;
    always_ff @(posedge clk) begin
        if (rst) req_prev <= 1'b0;
        else     req_prev <= conv_start;
    end

    logic req_edge;
    assign req_edge = conv_start && !req_prev;

    // R2
    start_load_chk: assert property (@(posedge clk) disable iff (rst)
        (conv_start && conv_done) |=> (!conv_done && sar_q == MSB_ONLY && !ser_bit));

    // R3
    retrigger_chk: assert property (@(posedge clk) disable iff (rst)
        (!conv_done && req_edge) |=> (!conv_done && sar_q == MSB_ONLY));

    // R9
    hold_result_chk: assert property (@(posedge clk) disable iff (rst)
        (conv_done && !conv_start) |=> (conv_done && $stable(sar_q)));

    // R10
    quiet_serial_chk: assert property (@(posedge clk) disable iff (rst)
        (conv_done && !conv_start) |=> !ser_bit);

    // R7
    early_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (!conv_done && short_stop && !req_edge) |=> (conv_done && $stable(sar_q)));

    // R10
    serial_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (!conv_done && !req_edge) |=> (ser_bit == $past(cmp_bit)));

    // R4
    done_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(conv_done) |-> $past(conv_start));

endmodule

bind sar_shortening sar_shortening_chk #(.WIDTH(WIDTH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .conv_start (conv_start),
    .short_stop (short_stop),
    .cmp_bit    (cmp_bit),
    .sar_q      (sar_q),
    .conv_done  (conv_done),
    .ser_bit    (ser_bit)
);

// File: tb/sar_shortening_tb.sv
module sar_shortening_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       conv_start = 1'b0;
    logic       short_stop = 1'b0;
    logic       cmp_bit = 1'b0;
    logic [7:0] sar_q;
    logic       conv_done;
    logic       ser_bit;

    always #2 clk = ~clk;

    sar_shortening #(.WIDTH(8)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .conv_start (conv_start),
        .short_stop (short_stop),
        .cmp_bit    (cmp_bit),
        .sar_q      (sar_q),
        .conv_done  (conv_done),
        .ser_bit    (ser_bit)
    );

    typedef struct {
        logic [7:0] q;
        logic       eoc;
        logic       sout;
        string      tag;
    } exp_t;

    exp_t exp_fifo[$];
    int   checks = 0;
    int   fails  = 0;
    bit   finished = 0;

    // model state of the expected outputs
    logic [7:0] m_q = 8'h00;
    logic       m_eoc = 1'b1;
    int         m_k = 7;

    task automatic check(input string tag, input logic [7:0] aq, input logic ae, input logic as_,
                         input logic [7:0] eq, input logic ee, input logic es);
        checks++;
        if (aq !== eq || ae !== ee || as_ !== es) begin
            fails++;
            $display("FAIL %s: actual q=%h eoc=%b sout=%b expected q=%h eoc=%b sout=%b",
                     tag, aq, ae, as_, eq, ee, es);
        end
    endtask

    // monitor: compare after each rising edge, away from it
    always @(posedge clk) begin
        #1;
        if (exp_fifo.size() > 0) begin
            exp_t e;
            e = exp_fifo.pop_front();
            check(e.tag, sar_q, conv_done, ser_bit, e.q, e.eoc, e.sout);
        end
    end

    // driver: one clock of stimulus plus the expected state after it
    task automatic cyc(input logic s, input logic f, input logic dd,
                       input logic [7:0] eq, input logic ee, input logic es, input string tag);
        exp_t e;
        @(negedge clk);
        conv_start = s;
        short_stop = f;
        cmp_bit    = dd;
        e.q = eq; e.eoc = ee; e.sout = es; e.tag = tag;
        exp_fifo.push_back(e);
        m_q = eq;
        m_eoc = ee;
    endtask

    task automatic start_conv(input string tag);
        cyc(1'b1, 1'b0, 1'b1, 8'h80, 1'b0, 1'b0, tag);
        m_k = 7;
    endtask

    // decide trial bit m_k against an analog value vin
    task automatic step(input logic [7:0] vin, input logic s, input string tag);
        logic       dd;
        logic [7:0] nq;
        dd = (m_q <= vin);
        nq = m_q & ~(8'h01 << m_k);
        if (dd) nq = nq | (8'h01 << m_k);
        if (m_k > 0) nq = nq | (8'h01 << (m_k - 1));
        cyc(s, 1'b0, dd, nq, (m_k == 0), dd, (m_k == 0) ? "R6" : tag);
        m_k = m_k - 1;
    endtask

    task automatic hold(input int n, input logic f, input string tag);
        for (int i = 0; i < n; i++) begin
            cyc(1'b0, f, i[0], m_q, 1'b1, 1'b0, tag);
        end
    endtask

    task automatic full_conv(input logic [7:0] vin, input logic s);
        start_conv("R2");
        for (int i = 0; i < 8; i++) step(vin, s, s ? "R4" : "R5");
        // final result must equal the analog value (R6)
        if (m_q !== vin) begin
            checks++; fails++;
            $display("FAIL R6: model result %h expected %h", m_q, vin);
        end
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: state during reset
        check("R1", sar_q, conv_done, ser_bit, 8'h00, 1'b1, 1'b0);
        @(negedge clk);
        rst = 1'b0;
        // R1: idle after release
        cyc(1'b0, 1'b0, 1'b1, 8'h00, 1'b1, 1'b0, "R1");
        cyc(1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, "R1");

        // full conversion, start held high throughout (R4), then hold with short_stop high (R8)
        full_conv(8'hA5, 1'b1);
        hold(3, 1'b1, "R8");
        hold(2, 1'b0, "R9");

        // extremes with start low during conversion (R5)
        full_conv(8'h00, 1'b0);
        hold(2, 1'b0, "R10");
        full_conv(8'hFF, 1'b0);
        hold(2, 1'b0, "R9");

        // R7: shortened conversion, short_stop follows sar_q[1]
        start_conv("R2");
        for (int i = 0; i < 6; i++) step(8'h6B, 1'b0, "R7");
        cyc(1'b0, 1'b1, 1'b1, m_q, 1'b1, 1'b1, "R7");
        check("R7", m_q, m_eoc, 1'b0, {6'b011010, 2'b10}, 1'b1, 1'b0);
        hold(3, 1'b1, "R8");

        // R3: retrigger in the middle of a conversion
        start_conv("R2");
        for (int i = 0; i < 3; i++) step(8'h3C, 1'b0, "R5");
        start_conv("R3");
        for (int i = 0; i < 8; i++) step(8'h3C, 1'b0, "R5");
        hold(1, 1'b0, "R9");

        // R11: free run, start driven from the done flag
        for (int r = 0; r < 3; r++) begin
            start_conv("R11");
            for (int i = 0; i < 8; i++) step(8'h5A ^ r[7:0], m_eoc, "R11");
        end
        hold(2, 1'b0, "R9");

        @(posedge clk);
        #2;
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule